// File: doc/BRIEF.md
# Host-to-SRAM block fill DMA channel

This block is a single DMA channel that copies one contiguous block of bytes from host memory into local SRAM. Software describes the transfer through a small register window: a destination SRAM address, a 64-bit source address written as two 32-bit halves, and a byte count. A final write to the control register, with the start bit set, launches the copy. The channel issues one host read per 32-bit word, waits for the returned data, and writes it to SRAM with byte enables. Both addresses advance by four bytes per beat.

The byte count does not have to be a multiple of four. The last SRAM write enables only the lanes that still hold payload. A count of zero finishes at once and makes no memory access. On completion the channel goes idle and sets a sticky done flag. It also raises a one-cycle interrupt pulse when the interrupt-target field selects the host driver. Writing the control register with the start bit clear stops the channel at any time. Any partly finished transfer is dropped.

Top module: `dram_fill_dma`

## Requirements
- R1: After reset every register reads 0, rd_req_valid, sram_we and irq_host are low.
- R2: While idle, the SRAM destination (offset 0x64), source low half (0x68), source high half (0x6C) and byte count (0x70) read back exactly what was written.
- R3: A control write (offset 0x60) with bit 31 set while idle starts a transfer from the values held at that moment. Beat k reads source+4k, with carry across the two halves, and writes SRAM destination+4k with the word returned for that read. There are ceil(count/4) beats, issued in order.
- R4: rd_req_snoop equals control bit 0 on every read request.
- R5: Lane i of sram_be covers sram_wdata bits 8i+7:8i. Every beat with 4 or more bytes left uses 4'hF. A final beat with r bytes left (r = 1, 2 or 3) enables lanes 0 to r-1 only (4'h1, 4'h3, 4'h7).
- R6: A start with byte count 0 makes no read request and no SRAM write, and still completes: done is set and the interrupt rule applies.
- R7: On completion, control bits 31 and 17 (busy) read 0 and bit 16 (done) reads 1. Done stays set until a control write with bit 16 set clears it. If completion and that clear fall in the same cycle, done ends up set.
- R8: Completion pulses irq_host high for exactly one cycle when control bits 25:24 hold 2'b01. With any other value there is no pulse.
- R9: A control write with bit 31 clear while busy returns the channel to idle. No further SRAM write follows, done is not set and irq_host does not pulse. This holds even when the write lands on the cycle of the last SRAM write. A read response still in flight is discarded.
- R10: While busy, control bits 31 and 17 read 1. Writes to 0x64..0x70 are ignored, and a control write with bit 31 set is ignored entirely.
- R11: Control bits 30, 25:24 and 0 read back as written. Unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| rd_req_valid | output | 1 | Host read request valid |
| rd_req_ready | input | 1 | Host accepts the read request |
| rd_req_addr | output | 64 | Host read byte address |
| rd_req_snoop | output | 1 | Snoop attribute of the request |
| rd_rsp_valid | input | 1 | Host read data valid |
| rd_rsp_data | input | 32 | Host read data |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 32 | SRAM write byte address |
| sram_wdata | output | 32 | SRAM write data |
| sram_be | output | 4 | SRAM byte lane enables |
| irq_host | output | 1 | One-cycle completion interrupt |

## Verification
Completion of a transfer and a software write to the control register can fall in the same cycle. The bench forces both orderings. In the first, it watches for the only SRAM write of a one-word transfer and issues a stop write in that same cycle. It then judges that the SRAM write still happened, but that done stays clear and no interrupt fires. In the second, it waits one cycle past the last write, when completion is being recorded, and issues a done-clear write in that cycle. It then expects done to read 1 and exactly one interrupt pulse.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
    localparam int REG_DW = 32;

    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_DST  = 8'h64;
    localparam logic [7:0] OFS_SRCL = 8'h68;
    localparam logic [7:0] OFS_SRCH = 8'h6C;
    localparam logic [7:0] OFS_LEN  = 8'h70;

    localparam int CB_START = 31;
    localparam int CB_EN    = 30;
    localparam int CB_TGT   = 24;
    localparam int CB_BUSY  = 17;
    localparam int CB_DONE  = 16;
    localparam int CB_SNOOP = 0;

    localparam logic [1:0] TGT_HOST = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WR   = 2'd3
    } eng_st_e;
endpackage

// File: rtl/dfd_lane_mask.sv
module dfd_lane_mask #(
    parameter int LANES = 4,
    parameter int CW    = 32
) (
    input  logic [CW-1:0]    left_i,
    output logic [LANES-1:0] be_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_o[i] = (left_i > CW'(i));
    end
endmodule

// File: rtl/dfd_engine.sv
module dfd_engine
    import dfd_pkg::*;
#(
    parameter int HAW = 64,
    parameter int SAW = 32,
    parameter int DW  = 32,
    parameter int CW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             snoop_i,
    input  logic [HAW-1:0]   cfg_src_i,
    input  logic [SAW-1:0]   cfg_dst_i,
    input  logic [CW-1:0]    cfg_len_i,
    output logic             rd_req_valid_o,
    input  logic             rd_req_ready_i,
    output logic [HAW-1:0]   rd_req_addr_o,
    output logic             rd_req_snoop_o,
    input  logic             rd_rsp_valid_i,
    input  logic [DW-1:0]    rd_rsp_data_i,
    output logic             sram_we_o,
    output logic [SAW-1:0]   sram_addr_o,
    output logic [DW-1:0]    sram_wdata_o,
    output logic [DW/8-1:0]  sram_be_o,
    output logic             busy_o,
    output logic             fin_o
);
    localparam int STEP = DW / 8;

    typedef struct packed {
        eng_st_e         st;
        logic [HAW-1:0]  src;
        logic [SAW-1:0]  dst;
        logic [CW-1:0]   left;
        logic [DW-1:0]   wd;
        logic [STEP-1:0] be;
        logic            fin;
    } eng_s;

    eng_s q, d;
    logic [STEP-1:0] lane_be;

    dfd_lane_mask #(.LANES(STEP), .CW(CW)) u_mask (
        .left_i (q.left),
        .be_o   (lane_be)
    );

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.src  = cfg_src_i;
                    d.dst  = cfg_dst_i;
                    d.left = cfg_len_i;
                    if (cfg_len_i == '0) begin
                        d.fin = 1'b1;
                    end else begin
                        d.st = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (rd_req_ready_i) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rd_rsp_valid_i) begin
                    d.wd = rd_rsp_data_i;
                    d.be = lane_be;
                    d.st = ST_WR;
                end
            end
            ST_WR: begin
                d.src = q.src + HAW'(STEP);
                d.dst = q.dst + SAW'(STEP);
                if (q.left <= CW'(STEP)) begin
                    d.left = '0;
                    d.st   = ST_IDLE;
                    d.fin  = 1'b1;
                end else begin
                    d.left = q.left - CW'(STEP);
                    d.st   = ST_REQ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (abort_i) begin
            d.st  = ST_IDLE;
            d.fin = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_req_valid_o = (q.st == ST_REQ);
    assign rd_req_addr_o  = q.src;
    assign rd_req_snoop_o = snoop_i;
    assign sram_we_o      = (q.st == ST_WR);
    assign sram_addr_o    = q.dst;
    assign sram_wdata_o   = q.wd;
    assign sram_be_o      = q.be;
    assign busy_o         = (q.st != ST_IDLE);
    assign fin_o          = q.fin;

    AST_BE_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_o |-> (sram_be_o != '0) && ((sram_be_o & (sram_be_o + STEP'(1))) == '0)); // R5
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_o && !sram_we_o && !fin_o); // R9
    AST_FIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> $past(sram_we_o) || $past(start_i && cfg_len_i == '0)); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o && !rd_req_ready_i && !abort_i |=> rd_req_valid_o && $stable(rd_req_addr_o)); // R3
endmodule

// File: rtl/dfd_regs.sv
module dfd_regs
    import dfd_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int HAW    = 64,
    parameter int SAW    = 32,
    parameter int CW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic              busy_i,
    input  logic              fin_i,
    output logic              start_o,
    output logic              abort_o,
    output logic              snoop_o,
    output logic [HAW-1:0]    cfg_src_o,
    output logic [SAW-1:0]    cfg_dst_o,
    output logic [CW-1:0]     cfg_len_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [SAW-1:0] dst;
        logic [HAW-1:0] src;
        logic [CW-1:0]  len;
        logic           snoop;
        logic           en;
        logic [1:0]     tgt;
        logic           done;
        logic           irq;
    } reg_s;

    reg_s q, d;

    logic hit_ctrl, hit_dst, hit_srcl, hit_srch, hit_len;
    logic ctl_acc, cfg_acc;

    assign hit_ctrl = reg_wr_i && (reg_addr_i == REG_AW'(OFS_CTRL));
    assign hit_dst  = reg_wr_i && (reg_addr_i == REG_AW'(OFS_DST));
    assign hit_srcl = reg_wr_i && (reg_addr_i == REG_AW'(OFS_SRCL));
    assign hit_srch = reg_wr_i && (reg_addr_i == REG_AW'(OFS_SRCH));
    assign hit_len  = reg_wr_i && (reg_addr_i == REG_AW'(OFS_LEN));

    assign ctl_acc  = hit_ctrl && !(busy_i && reg_wdata_i[CB_START]);
    assign cfg_acc  = !busy_i;
    assign start_o  = hit_ctrl && reg_wdata_i[CB_START] && !busy_i;
    assign abort_o  = hit_ctrl && !reg_wdata_i[CB_START] && busy_i;

    always_comb begin
        d     = q;
        d.irq = fin_i && (q.tgt == TGT_HOST);
        if (cfg_acc && hit_dst) begin
            d.dst = SAW'(reg_wdata_i);
        end
        if (cfg_acc && hit_srcl) begin
            d.src[REG_DW-1:0] = reg_wdata_i;
        end
        if (cfg_acc && hit_srch) begin
            d.src[HAW-1:REG_DW] = reg_wdata_i[HAW-REG_DW-1:0];
        end
        if (cfg_acc && hit_len) begin
            d.len = CW'(reg_wdata_i);
        end
        if (ctl_acc) begin
            d.snoop = reg_wdata_i[CB_SNOOP];
            d.en    = reg_wdata_i[CB_EN];
            d.tgt   = reg_wdata_i[CB_TGT+1:CB_TGT];
            if (reg_wdata_i[CB_DONE]) begin
                d.done = 1'b0;
            end
        end
        if (fin_i) begin
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == REG_AW'(OFS_CTRL)) begin
            reg_rdata_o[CB_START]          = busy_i;
            reg_rdata_o[CB_EN]             = q.en;
            reg_rdata_o[CB_TGT+1:CB_TGT]   = q.tgt;
            reg_rdata_o[CB_BUSY]           = busy_i;
            reg_rdata_o[CB_DONE]           = q.done;
            reg_rdata_o[CB_SNOOP]          = q.snoop;
        end else if (reg_addr_i == REG_AW'(OFS_DST)) begin
            reg_rdata_o = REG_DW'(q.dst);
        end else if (reg_addr_i == REG_AW'(OFS_SRCL)) begin
            reg_rdata_o = q.src[REG_DW-1:0];
        end else if (reg_addr_i == REG_AW'(OFS_SRCH)) begin
            reg_rdata_o = REG_DW'(q.src[HAW-1:REG_DW]);
        end else if (reg_addr_i == REG_AW'(OFS_LEN)) begin
            reg_rdata_o = REG_DW'(q.len);
        end
    end

    assign snoop_o   = q.snoop;
    assign cfg_src_o = q.src;
    assign cfg_dst_o = q.dst;
    assign cfg_len_o = q.len;
    assign irq_o     = q.irq;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && reg_wr_i && reg_addr_i != REG_AW'(OFS_CTRL) |=> $stable(q.dst) && $stable(q.src) && $stable(q.len)); // R10
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(fin_i) && $past(q.tgt) == TGT_HOST); // R8
    AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(fin_i)); // R7
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o && !q.done |=> !q.done && !irq_o); // R9
endmodule

// File: rtl/dram_fill_dma.sv
module dram_fill_dma
    import dfd_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int SAW    = 32,
    parameter int DW     = 32,
    parameter int CW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [63:0]       rd_req_addr,
    output logic              rd_req_snoop,
    input  logic              rd_rsp_valid,
    input  logic [DW-1:0]     rd_rsp_data,
    output logic              sram_we,
    output logic [SAW-1:0]    sram_addr,
    output logic [DW-1:0]     sram_wdata,
    output logic [DW/8-1:0]   sram_be,
    output logic              irq_host
);
    localparam int HAW = 2 * REG_DW;

    logic           start, abort, snoop, busy, fin;
    logic [HAW-1:0] cfg_src;
    logic [SAW-1:0] cfg_dst;
    logic [CW-1:0]  cfg_len;

    dfd_regs #(.REG_AW(REG_AW), .HAW(HAW), .SAW(SAW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .busy_i      (busy),
        .fin_i       (fin),
        .start_o     (start),
        .abort_o     (abort),
        .snoop_o     (snoop),
        .cfg_src_o   (cfg_src),
        .cfg_dst_o   (cfg_dst),
        .cfg_len_o   (cfg_len),
        .irq_o       (irq_host)
    );

    dfd_engine #(.HAW(HAW), .SAW(SAW), .DW(DW), .CW(CW)) u_eng (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .abort_i        (abort),
        .snoop_i        (snoop),
        .cfg_src_i      (cfg_src),
        .cfg_dst_i      (cfg_dst),
        .cfg_len_i      (cfg_len),
        .rd_req_valid_o (rd_req_valid),
        .rd_req_ready_i (rd_req_ready),
        .rd_req_addr_o  (rd_req_addr),
        .rd_req_snoop_o (rd_req_snoop),
        .rd_rsp_valid_i (rd_rsp_valid),
        .rd_rsp_data_i  (rd_rsp_data),
        .sram_we_o      (sram_we),
        .sram_addr_o    (sram_addr),
        .sram_wdata_o   (sram_wdata),
        .sram_be_o      (sram_be),
        .busy_o         (busy),
        .fin_o          (fin)
    );
endmodule

// File: tb/dram_fill_dma_tb.sv
module dram_fill_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [63:0] rd_req_addr;
    logic        rd_req_snoop;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        sram_we;
    logic [31:0] sram_addr;
    logic [31:0] sram_wdata;
    logic [3:0]  sram_be;
    logic        irq_host;

    always #2.5 clk = ~clk;

    dram_fill_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_snoop(rd_req_snoop),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_be(sram_be), .irq_host(irq_host)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
    } wr_t;

    wr_t         exp_wr[$];
    logic [63:0] exp_rd[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          irq_cnt = 0;
    int          req_cnt = 0;
    int          wr_cnt = 0;
    int          stall = 0;
    bit          abort_mode = 1'b0;
    bit          host_busy = 1'b0;
    bit          exp_snoop = 1'b0;
    logic [31:0] rv;

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[31:0] ^ {a[47:32], 16'hC35A};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // driver: pushes expected reads and writes, then programs the channel
    task automatic run_xfer(input logic [31:0] dst, input logic [63:0] src, input logic [31:0] len,
                            input logic [31:0] ctl, input bit push);
        if (push) begin
            for (int k = 0; k < int'((len + 3) / 4); k++) begin
                wr_t w;
                logic [63:0] a;
                int rem;
                a = src + 64'(4 * k);
                rem = int'(len) - 4 * k;
                w.a = dst + 32'(4 * k);
                w.d = mem_word(a);
                w.be = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
                exp_rd.push_back(a);
                exp_wr.push_back(w);
            end
        end
        exp_snoop = ctl[0];
        wr_reg(8'h60, 32'h0001_0000);
        wr_reg(8'h64, dst);
        wr_reg(8'h68, src[31:0]);
        wr_reg(8'h6C, src[63:32]);
        wr_reg(8'h70, len);
        wr_reg(8'h60, ctl);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd_reg(8'h60, v);
            if (!v[17]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // host memory model
    initial begin
        forever begin
            @(negedge clk);
            stall++;
            rd_req_ready = (stall % 3) != 0;
            if (rd_req_valid && rd_req_ready) begin
                logic [63:0] a;
                a = rd_req_addr;
                host_busy = 1'b1;
                req_cnt++;
                if (!abort_mode) begin
                    logic [63:0] e;
                    e = (exp_rd.size() > 0) ? exp_rd.pop_front() : 64'hX;
                    check(a === e, "R3 read address", a, e);
                    check(rd_req_snoop === exp_snoop, "R4 snoop", 64'(rd_req_snoop), 64'(exp_snoop));
                end
                @(posedge clk);
                @(negedge clk);
                rd_req_ready = 1'b0;
                @(negedge clk);
                rd_rsp_valid = 1'b1;
                rd_rsp_data = mem_word(a);
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                host_busy = 1'b0;
            end
        end
    end

    // monitor: compares SRAM writes against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (sram_we) begin
                wr_cnt++;
                if (!abort_mode) begin
                    if (exp_wr.size() == 0) begin
                        check(1'b0, "R3 unexpected SRAM write", 64'(sram_addr), 64'h0);
                    end else begin
                        wr_t w;
                        w = exp_wr.pop_front();
                        check(sram_addr === w.a && sram_wdata === w.d && sram_be === w.be,
                              "R3/R5 SRAM write",
                              {sram_addr, sram_wdata[27:0], sram_be},
                              {w.a, w.d[27:0], w.be});
                    end
                end
            end
            if (irq_host) irq_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int irq0, req0, wr0;
        repeat (4) @(negedge clk);
        // R1 reset state
        rd_reg(8'h60, rv); check(rv == 0, "R1 ctrl reset", 64'(rv), 0);
        rd_reg(8'h64, rv); check(rv == 0, "R1 dst reset", 64'(rv), 0);
        rd_reg(8'h68, rv); check(rv == 0, "R1 src low reset", 64'(rv), 0);
        rd_reg(8'h70, rv); check(rv == 0, "R1 len reset", 64'(rv), 0);
        check(!rd_req_valid && !sram_we && !irq_host, "R1 outputs idle",
              {rd_req_valid, sram_we, irq_host}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_reg(8'h60, rv); check(rv == 0, "R1 ctrl after release", 64'(rv), 0);

        // R2 readback, R11 control fields
        wr_reg(8'h64, 32'h0000_1230);
        wr_reg(8'h68, 32'hCAFE_0010);
        wr_reg(8'h6C, 32'h0000_0077);
        wr_reg(8'h70, 32'h0000_0123);
        rd_reg(8'h64, rv); check(rv == 32'h0000_1230, "R2 dst readback", 64'(rv), 64'h1230);
        rd_reg(8'h68, rv); check(rv == 32'hCAFE_0010, "R2 src low readback", 64'(rv), 64'hCAFE0010);
        rd_reg(8'h6C, rv); check(rv == 32'h0000_0077, "R2 src high readback", 64'(rv), 64'h77);
        rd_reg(8'h70, rv); check(rv == 32'h0000_0123, "R2 len readback", 64'(rv), 64'h123);
        wr_reg(8'h60, 32'h7EFE_FFFF & 32'h4200_0001);
        rd_reg(8'h60, rv); check(rv == 32'h4200_0001, "R11 ctrl fields", 64'(rv), 64'h42000001);

        // R3/R4/R7/R8 aligned with carry across halves
        irq0 = irq_cnt;
        run_xfer(32'h0000_0100, 64'h0000_0001_FFFF_FFF8, 32'd16, 32'h8100_0001, 1'b1);
        wait_idle();
        check(exp_wr.size() == 0, "R3 all beats written", 64'(exp_wr.size()), 0);
        check(irq_cnt == irq0 + 1, "R8 one pulse", 64'(irq_cnt), 64'(irq0 + 1));
        rd_reg(8'h60, rv); check(rv == 32'h0101_0001, "R7 done set busy clear", 64'(rv), 64'h01010001);
        wr_reg(8'h60, 32'h0101_0001);
        rd_reg(8'h60, rv); check(rv == 32'h0100_0001, "R7 done cleared", 64'(rv), 64'h01000001);

        // R5 partial tails of 1, 2, 3 bytes
        for (int t = 5; t <= 7; t++) begin
            run_xfer(32'h0000_0200 + 32'(t * 16), 64'h0000_0000_0000_4000, 32'(t), 32'h0100_0000 | 32'h8000_0000, 1'b1);
            wait_idle();
            check(exp_wr.size() == 0, "R5 tail beats written", 64'(exp_wr.size()), 0);
        end

        // R6 zero count
        irq0 = irq_cnt; req0 = req_cnt; wr0 = wr_cnt;
        run_xfer(32'h0000_0300, 64'h0000_0000_0000_8000, 32'd0, 32'h8100_0000, 1'b1);
        repeat (4) @(negedge clk);
        check(req_cnt == req0 && wr_cnt == wr0, "R6 no access", 64'(req_cnt - req0 + wr_cnt - wr0), 0);
        rd_reg(8'h60, rv); check(rv[16] && !rv[17], "R6 done on zero", 64'(rv), 64'h01010000);
        check(irq_cnt == irq0 + 1, "R6 irq on zero", 64'(irq_cnt), 64'(irq0 + 1));

        // R8 other targets: no pulse
        irq0 = irq_cnt;
        run_xfer(32'h0000_0400, 64'h0000_0000_0000_9000, 32'd8, 32'h8000_0000, 1'b1);
        wait_idle();
        run_xfer(32'h0000_0440, 64'h0000_0000_0000_9100, 32'd4, 32'h8200_0000, 1'b1);
        wait_idle();
        rd_reg(8'h60, rv); check(rv[16] == 1'b1, "R7 done with target 2", 64'(rv), 64'h02010000);
        check(irq_cnt == irq0, "R8 no pulse for targets 0 and 2", 64'(irq_cnt), 64'(irq0));

        // R10 busy: config and restart ignored
        irq0 = irq_cnt;
        run_xfer(32'h0000_1000, 64'h0000_0003_0000_0000, 32'd64, 32'h8100_0001, 1'b1);
        repeat (3) @(negedge clk);
        rd_reg(8'h60, rv); check(rv[31] && rv[17], "R10 busy bits", 64'(rv), 64'h80020000);
        wr_reg(8'h64, 32'hDEAD_BEE0);
        wr_reg(8'h70, 32'h0000_0004);
        wr_reg(8'h60, 32'h8200_0000);
        rd_reg(8'h64, rv); check(rv == 32'h0000_1000, "R10 dst write ignored", 64'(rv), 64'h1000);
        rd_reg(8'h70, rv); check(rv == 32'd64, "R10 len write ignored", 64'(rv), 64);
        rd_reg(8'h60, rv); check(rv[25:24] == 2'b01 && rv[0], "R10 restart write ignored", 64'(rv), 64'h81020001);
        wait_idle();
        check(exp_wr.size() == 0, "R10 transfer unaffected", 64'(exp_wr.size()), 0);
        check(irq_cnt == irq0 + 1, "R10 single completion", 64'(irq_cnt), 64'(irq0 + 1));

        // R9 stop mid transfer
        abort_mode = 1'b1;
        irq0 = irq_cnt;
        run_xfer(32'h0000_2000, 64'h0000_0000_0001_0000, 32'd256, 32'h8100_0000, 1'b0);
        repeat (12) @(negedge clk);
        wr_reg(8'h60, 32'h0100_0000);
        repeat (2) @(negedge clk);
        while (host_busy) @(negedge clk);
        wr0 = wr_cnt;
        repeat (20) @(negedge clk);
        check(wr_cnt == wr0, "R9 no write after stop", 64'(wr_cnt), 64'(wr0));
        rd_reg(8'h60, rv); check(!rv[17] && !rv[16], "R9 idle without done", 64'(rv), 64'h01000000);
        check(irq_cnt == irq0, "R9 no irq after stop", 64'(irq_cnt), 64'(irq0));
        abort_mode = 1'b0;

        // R9 stop in the cycle of the last write
        irq0 = irq_cnt;
        run_xfer(32'h0000_3000, 64'h0000_0000_0002_0000, 32'd4, 32'h8100_0000, 1'b1);
        do @(negedge clk); while (!sram_we);
        reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 32'h0100_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_wr.size() == 0, "R9 last write still made", 64'(exp_wr.size()), 0);
        rd_reg(8'h60, rv); check(!rv[16] && !rv[17], "R9 collision no done", 64'(rv), 64'h01000000);
        check(irq_cnt == irq0, "R9 collision no irq", 64'(irq_cnt), 64'(irq0));

        // R7 done-clear in the completion cycle: set wins
        irq0 = irq_cnt;
        run_xfer(32'h0000_3100, 64'h0000_0000_0002_1000, 32'd4, 32'h8100_0000, 1'b1);
        do @(negedge clk); while (!sram_we);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 32'h0101_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rd_reg(8'h60, rv); check(rv[16] == 1'b1, "R7 set beats clear", 64'(rv), 64'h01010000);
        check(irq_cnt == irq0 + 1, "R8 collision pulse", 64'(irq_cnt), 64'(irq0 + 1));
        check(exp_wr.size() == 0 && exp_rd.size() == 0, "R3 scoreboard drained",
              64'(exp_wr.size() + exp_rd.size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule